// File: doc/BRIEF.md
# Two-Step Programmable Anode Pulse Driver

This block times the anode (segment) drive of a passive-matrix emissive display row by row. A free-running 8-bit tick counter divides time into 256-tick row periods. Each period opens with an optional reverse-bias interval, in which every anode is pulled low and the cathode side is forced high. The anode pulse follows at once: for a programmable number of ticks, each anode lane that has its pixel bit set in `seg_data` is driven high. When the display is switched off, the anodes rest in a selectable idle state: either driven low or released to high impedance.

Software writes bytes over a simple strobe interface. A select line separates command bytes from display-data bytes, and this block ignores display-data bytes. The 8-bit pulse-width register and the 8-bit reverse-interval register are each loaded in two steps. An arming command comes first. The very next command byte is then stored as the register value, whatever it encodes, and that write disarms the mode again. Every setting is copied into a working set only at the row-period boundary, so a row never carries a partial pulse.

Top module: `anode_pwm_driver`

## Requirements
- R1: After a synchronous active-low reset the tick count is 0 and then rises by one per clock, wrapping 255 to 0. The pulse width and reverse interval are 0, the display is off, the idle state is driven low (`anode_oe` all ones, `anode_out` zero), `cathode_high` is 0 and no arming is pending.
- R2: With the display on and a reverse interval of 0, a pulse-width value N from 0 to 239 makes `anode_out` equal `seg_data` while the count is below N, and zero for the rest of the period.
- R3: A pulse-width value from 8'hF0 to 8'hFF gives a pulse of exactly 240 ticks, the same as the value 240.
- R4: A pulse-width value is stored only when the byte follows the arming command 8'h80. Command bytes with no defined meaning (for example 8'h40) change nothing.
- R5: While either register is armed, the next command byte is stored as the register value even when it is another command (for example 8'hAE stored as pulse width 174 while the display stays on).
- R6: Storing the value byte disarms the mode, so the command byte that follows is decoded normally.
- R7: The reverse interval is armed with 8'h84 and loaded by the next command byte R. For counts below R, with the display on, `anode_out` is zero, `anode_oe` is all ones and `cathode_high` is 1; outside that interval `cathode_high` is 0.
- R8: The anode pulse starts at count R and lasts min(N,240) ticks, cut short at count 255 when R plus the width exceeds 256.
- R9: Command 8'hAE turns the display off and 8'hAF turns it on. While off there is no pulse and no reverse interval. Command 8'hA2 selects the driven-low idle state and 8'hA3 selects high impedance (`anode_oe` all zero, `anode_out` zero).
- R10: Settings written part-way through a period leave that period's outputs unchanged and take effect from the next count 0.
- R11: Writes with `wr_dsel` = 1 are display data. They load nothing and leave a pending arming in place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock; the counter advances once per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one byte per cycle in which it is high |
| wr_dsel | input | 1 | 0 = command byte, 1 = display-data byte (ignored) |
| wr_byte | input | 8 | Written byte |
| seg_data | input | NSEG | Pixel bits of the current row, one per anode lane |
| anode_out | output | NSEG | Anode drive level per lane |
| anode_oe | output | NSEG | Anode output enable per lane (0 = high impedance) |
| cathode_high | output | 1 | Forces all cathodes high during the reverse interval |

## Verification
The hardest case to reach from the ports is the lockout. A byte that is itself a valid command has to arrive while an arming is pending, and the bench must then show that the byte became a register value instead of acting as a command. The stimulus arms the pulse register and then sends the display-off code. A full row period is then checked to confirm that the display stayed on and that the pulse lasts 174 ticks. A display-data write is also placed between an arming and its value byte, to show that the pending arming survives it. The boundary rule is tested by rewriting the pulse width at count 100 of a period that is being checked tick by tick.

// File: rtl/anode_pwm_pkg.sv
// Shared types and command codes for the anode pulse driver.
// Assumes 8-bit configuration registers and an 8-bit row tick counter.
package anode_pwm_pkg;

    localparam int REG_W     = 8;
    localparam int DUTY_MAX  = 240;

    localparam logic [REG_W-1:0] OP_ARM_WIDTH = 8'h80;
    localparam logic [REG_W-1:0] OP_ARM_REV   = 8'h84;
    localparam logic [REG_W-1:0] OP_DISP_OFF  = 8'hAE;
    localparam logic [REG_W-1:0] OP_DISP_ON   = 8'hAF;
    localparam logic [REG_W-2:0] OP_IDLE_SEL  = 7'b1010_001;

    typedef enum logic [1:0] {
        ARM_NONE  = 2'd0,
        ARM_WIDTH = 2'd1,
        ARM_REV   = 2'd2
    } arm_e;

    typedef struct packed {
        logic [REG_W-1:0] width;
        logic [REG_W-1:0] rev;
        logic             disp_on;
        logic             idle_hiz;
    } drv_cfg_t;

    localparam drv_cfg_t CFG_RESET = '{width: '0, rev: '0, disp_on: 1'b0, idle_hiz: 1'b0};

endpackage

// File: rtl/anode_cmd_decoder.sv
// Command decoder with a two-step register load.
// An arming command makes the next command byte a register value, and
// storing that value disarms the mode. Display-data bytes are ignored.
// Assumes one byte per cycle in which wr_en is high.
module anode_cmd_decoder
    import anode_pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_dsel,
    input  logic [REG_W-1:0] wr_byte,
    output drv_cfg_t         cfg_sh,
    output arm_e             arm_q
);

    drv_cfg_t cfg_nx;
    arm_e     arm_nx;
    logic     cmd_wr;

    assign cmd_wr = wr_en && !wr_dsel;

    // Next-state decode of one command byte
    always_comb begin
        cfg_nx = cfg_sh;
        arm_nx = arm_q;
        if (cmd_wr) begin
            unique case (arm_q)
                ARM_WIDTH: begin
                    cfg_nx.width = wr_byte;
                    arm_nx       = ARM_NONE;
                end
                ARM_REV: begin
                    cfg_nx.rev = wr_byte;
                    arm_nx     = ARM_NONE;
                end
                default: begin
                    if (wr_byte == OP_ARM_WIDTH) begin
                        arm_nx = ARM_WIDTH;
                    end else if (wr_byte == OP_ARM_REV) begin
                        arm_nx = ARM_REV;
                    end else if (wr_byte == OP_DISP_OFF) begin
                        cfg_nx.disp_on = 1'b0;
                    end else if (wr_byte == OP_DISP_ON) begin
                        cfg_nx.disp_on = 1'b1;
                    end else if (wr_byte[REG_W-1:1] == OP_IDLE_SEL) begin
                        cfg_nx.idle_hiz = wr_byte[0];
                    end
                end
            endcase
        end
    end

    // Register the pending settings and the arming state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_sh <= CFG_RESET;
            arm_q  <= ARM_NONE;
        end else begin
            cfg_sh <= cfg_nx;
            arm_q  <= arm_nx;
        end
    end

endmodule

// File: rtl/anode_row_timer.sv
// Free-running row tick counter and boundary latch.
// Pending settings are copied to the working set on the wrap from the
// last count to zero, so a period always uses a single configuration.
module anode_row_timer
    import anode_pwm_pkg::*;
#(
    parameter int CNT_W = REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  drv_cfg_t         cfg_sh,
    output logic [CNT_W-1:0] cnt_q,
    output drv_cfg_t         cfg_act
);

    logic last_tick;

    assign last_tick = &cnt_q;

    // Advance the tick count every clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Adopt the pending settings at the period boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_act <= CFG_RESET;
        end else if (last_tick) begin
            cfg_act <= cfg_sh;
        end
    end

endmodule

// File: rtl/anode_phase_gen.sv
// Row phase decode and per-lane output stage.
// The reverse interval covers counts [0, rev). The anode pulse covers
// [rev, rev + min(width, DUTY_MAX)) and is clipped at the end of the period.
// With the display off the lanes rest low or at high impedance.
module anode_phase_gen
    import anode_pwm_pkg::*;
#(
    parameter int NSEG  = 128,
    parameter int CNT_W = REG_W
) (
    input  logic [CNT_W-1:0] cnt_q,
    input  drv_cfg_t         cfg_act,
    input  logic [NSEG-1:0]  seg_data,
    output logic [NSEG-1:0]  anode_out,
    output logic [NSEG-1:0]  anode_oe,
    output logic             cathode_high
);

    localparam int SUM_W = CNT_W + 1;
    localparam logic [REG_W-1:0] WIDTH_CAP = REG_W'(DUTY_MAX);

    logic [REG_W-1:0] width_eff;
    logic [SUM_W-1:0] pulse_end;
    logic             in_rev;
    logic             in_pulse;
    logic             lane_drive;

    // Clamp the programmed width to the largest legal pulse
    always_comb begin
        width_eff = (cfg_act.width > WIDTH_CAP) ? WIDTH_CAP : cfg_act.width;
    end

    // Decide which phase the current tick belongs to
    always_comb begin
        pulse_end  = SUM_W'(cfg_act.rev) + SUM_W'(width_eff);
        in_rev     = cfg_act.disp_on && (SUM_W'(cnt_q) < SUM_W'(cfg_act.rev));
        in_pulse   = cfg_act.disp_on && !in_rev && (SUM_W'(cnt_q) < pulse_end);
        lane_drive = cfg_act.disp_on || !cfg_act.idle_hiz;
    end

    assign cathode_high = in_rev;

    // Per-lane output stage
    for (genvar g = 0; g < NSEG; g++) begin : g_lane
        assign anode_out[g] = in_pulse && seg_data[g];
        assign anode_oe[g]  = lane_drive;
    end

endmodule

// File: rtl/anode_pwm_driver.sv
// Top level of the anode pulse driver: command decoder, row timer and
// phase generator. Assumes a single clock and a synchronous active-low reset.
module anode_pwm_driver
    import anode_pwm_pkg::*;
#(
    parameter int NSEG = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_dsel,
    input  logic [7:0]       wr_byte,
    input  logic [NSEG-1:0]  seg_data,
    output logic [NSEG-1:0]  anode_out,
    output logic [NSEG-1:0]  anode_oe,
    output logic             cathode_high
);

    localparam int CNT_W = REG_W;

    drv_cfg_t         cfg_sh;
    drv_cfg_t         cfg_act;
    arm_e             arm_q;
    logic [CNT_W-1:0] cnt_q;

    anode_cmd_decoder u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_dsel (wr_dsel),
        .wr_byte (wr_byte),
        .cfg_sh  (cfg_sh),
        .arm_q   (arm_q)
    );

    anode_row_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_sh  (cfg_sh),
        .cnt_q   (cnt_q),
        .cfg_act (cfg_act)
    );

    anode_phase_gen #(.NSEG(NSEG), .CNT_W(CNT_W)) u_phs (
        .cnt_q        (cnt_q),
        .cfg_act      (cfg_act),
        .seg_data     (seg_data),
        .anode_out    (anode_out),
        .anode_oe     (anode_oe),
        .cathode_high (cathode_high)
    );

endmodule

// File: rtl/anode_pwm_checker.sv
// Property checker for the anode pulse driver, bound to the top level.
module anode_pwm_checker
    import anode_pwm_pkg::*;
#(
    parameter int NSEG = 128
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic            wr_dsel,
    input logic [7:0]      wr_byte,
    input logic [NSEG-1:0] anode_out,
    input logic [NSEG-1:0] anode_oe,
    input logic            cathode_high,
    input logic [7:0]      cnt_q,
    input arm_e            arm_q,
    input drv_cfg_t        cfg_sh,
    input drv_cfg_t        cfg_act
);

    // R7: reverse interval keeps every anode driven low
    a_r7_reverse_anodes_low: assert property (@(posedge clk) disable iff (!rst_n)
        cathode_high |-> (anode_out == '0 && anode_oe == '1));

    // R9: released lanes carry no level and no reverse bias
    a_r9_hiz_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (anode_oe != '1) |-> (anode_out == '0 && !cathode_high));

    // R3: without a reverse interval nothing is driven past tick 239
    a_r3_width_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_act.rev == '0 && cnt_q >= 8'd240) |-> (anode_out == '0));

    // R10: the working set changes only at the wrap to count 0
    a_r10_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != 8'd0) |-> $stable(cfg_act));

    // R4: the width register moves only after its arming
    a_r4_width_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_sh.width) |-> ($past(arm_q) == ARM_WIDTH));

    // R5: an armed command byte becomes the value, nothing else moves
    a_r5_armed_takes_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q == ARM_WIDTH && wr_en && !wr_dsel)
            |=> (cfg_sh.width == $past(wr_byte) && $stable(cfg_sh.disp_on)));

    // R6: the value byte disarms the mode
    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q != ARM_NONE && wr_en && !wr_dsel) |=> (arm_q == ARM_NONE));

    // R11: display-data bytes touch neither arming nor settings
    a_r11_data_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_dsel) |=> ($stable(arm_q) && $stable(cfg_sh)));

endmodule

bind anode_pwm_driver anode_pwm_checker #(.NSEG(NSEG)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_dsel      (wr_dsel),
    .wr_byte      (wr_byte),
    .anode_out    (anode_out),
    .anode_oe     (anode_oe),
    .cathode_high (cathode_high),
    .cnt_q        (cnt_q),
    .arm_q        (arm_q),
    .cfg_sh       (cfg_sh),
    .cfg_act      (cfg_act)
);

// File: tb/anode_pwm_driver_test.sv
`timescale 1ns/1ps
module anode_pwm_driver_test;

    localparam int NSEG = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic            wr_dsel = 1'b0;
    logic [7:0]      wr_byte = 8'h00;
    logic [NSEG-1:0] seg_data = '0;
    logic [NSEG-1:0] anode_out;
    logic [NSEG-1:0] anode_oe;
    logic            cathode_high;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // model of the settings, per the requirements
    int m_width = 0;
    int m_rev = 0;
    bit m_on = 1'b0;
    bit m_hiz = 1'b0;
    string cur_req = "R1";

    logic [7:0] tb_cnt;

    typedef struct packed {
        logic [7:0]      cnt;
        logic [NSEG-1:0] out;
        logic [NSEG-1:0] oe;
        logic            cath;
    } item_t;

    item_t sb[$];

    always #2 clk = ~clk;

    anode_pwm_driver #(.NSEG(NSEG)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_dsel(wr_dsel),
        .wr_byte(wr_byte), .seg_data(seg_data), .anode_out(anode_out),
        .anode_oe(anode_oe), .cathode_high(cathode_high)
    );

    // bench's own tick count (R1: 0 after reset, +1 per clock)
    always @(posedge clk) begin
        if (!rst_n) tb_cnt <= 8'd0;
        else        tb_cnt <= tb_cnt + 8'd1;
    end

    // monitor: pop the expected item for the current tick and compare
    always @(negedge clk) begin
        if (sb.size() > 0 && sb[0].cnt == tb_cnt) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (anode_out !== it.out || anode_oe !== it.oe || cathode_high !== it.cath) begin
                errors++;
                $display("FAIL %s tick %0d: out=%h oe=%h cath=%b expected out=%h oe=%h cath=%b",
                         cur_req, tb_cnt, anode_out, anode_oe, cathode_high,
                         it.out, it.oe, it.cath);
            end
        end
    end

    function automatic item_t model(input int c);
        item_t it;
        int w;
        w = (m_width > 240) ? 240 : m_width;
        it.cnt = c[7:0];
        if (!m_on) begin
            it.out  = '0;
            it.oe   = m_hiz ? '0 : '1;
            it.cath = 1'b0;
        end else begin
            it.oe   = '1;
            it.cath = (c < m_rev);
            it.out  = (c >= m_rev && c < m_rev + w) ? seg_data : '0;
        end
        return it;
    endfunction

    task automatic wr(input logic [7:0] b, input logic dsel = 1'b0);
        @(negedge clk);
        wr_en = 1'b1; wr_dsel = dsel; wr_byte = b;
        @(negedge clk);
        wr_en = 1'b0; wr_dsel = 1'b0;
    endtask

    task automatic set_width(input logic [7:0] b);
        wr(8'h80); wr(b);
    endtask

    task automatic set_rev(input logic [7:0] b);
        wr(8'h84); wr(b);
    endtask

    // driver: at tick 255 push the expectations for the whole next period
    task automatic expect_period(input string req);
        do @(negedge clk); while (tb_cnt != 8'd255);
        cur_req = req;
        for (int c = 0; c < 256; c++) sb.push_back(model(c));
    endtask

    task automatic drain();
        while (sb.size() > 0) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs while reset is held
        checks++;
        if (anode_out !== '0 || anode_oe !== '1 || cathode_high !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: out=%h oe=%h cath=%b expected out=0 oe=ffff cath=0",
                     anode_out, anode_oe, cathode_high);
        end
        rst_n = 1'b1;
        seg_data = 16'hA5C3;
        expect_period("R1"); drain();

        // R2: mid-range width
        wr(8'hAF); set_width(8'd64);
        m_on = 1'b1; m_width = 64;
        expect_period("R2"); drain();

        // R3: saturation at F5 and FF
        seg_data = 16'h3C5A;
        set_width(8'hF5); m_width = 245;
        expect_period("R3"); drain();
        set_width(8'hFF); m_width = 255;
        expect_period("R3"); drain();

        // R2: largest unclamped width, then zero
        set_width(8'hEF); m_width = 239;
        expect_period("R2"); drain();
        set_width(8'h00); m_width = 0;
        expect_period("R2"); drain();
        set_width(8'd239); m_width = 239;

        // R4: an unarmed byte does not load the width
        wr(8'h40);
        expect_period("R4"); drain();

        // R11: display data between arming and value is ignored
        wr(8'h80); wr(8'h10, 1'b1); wr(8'h20); m_width = 32;
        expect_period("R11"); drain();

        // R5: an armed display-off code becomes width 174
        seg_data = 16'hFFFF;
        wr(8'h80); wr(8'hAE); m_width = 174;
        expect_period("R5"); drain();

        // R6 and R7: next command decodes normally and arms reverse
        set_rev(8'd32); m_rev = 32;
        expect_period("R6 R7"); drain();

        // R8: pulse clipped at the end of the period
        set_rev(8'd200); set_width(8'd100); m_rev = 200; m_width = 100;
        seg_data = 16'h0F0F;
        expect_period("R8"); drain();

        // R10: mid-period write waits for the boundary
        set_rev(8'd0); set_width(8'd10); m_rev = 0; m_width = 10;
        expect_period("R10");
        while (tb_cnt != 8'd100) @(negedge clk);
        set_width(8'd200);
        drain();
        m_width = 200;
        expect_period("R10"); drain();

        // R9: display off, idle low then high impedance then low again
        wr(8'hAE); m_on = 1'b0;
        expect_period("R9"); drain();
        wr(8'hA3); m_hiz = 1'b1;
        expect_period("R9"); drain();
        wr(8'hA2); m_hiz = 1'b0;
        expect_period("R9"); drain();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // watchdog
    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule